// File: doc/BRIEF.md
# SD Card Sector Transfer Engine

This block moves one or more consecutive 512-byte sectors between a local byte-wide buffer and a memory card that runs in SPI mode. It does not shift bits itself. Every byte goes through a byte-exchange port: the engine raises a request with a transmit byte, and a separate serializer answers with a completion strobe and the byte it received. The card must already be initialized. The addressing flag found during initialization (byte-addressed or block-addressed) is given to the engine at job start.

To start a job, software-side logic presents a 24-bit starting sector, a sector count and a direction, then pulses `start`. For each sector the engine builds a single-block command. It polls for the card's R1 reply and then handles the data phase. A read waits for the start token and stores the payload. A write sends the token and payload, then checks the data-response token and waits for the card to leave busy. The engine then steps the sector number and the buffer address and moves on to the next sector.

A job ends with exactly one pulse: `done`, `error` or `wpError`. At the end of every job the chip select and the interface enable are both released.

Top module: `sd_sector_engine`

## Requirements
- R1: Each sector starts with one 0xFF filler exchange and then a 6-byte command: opcode 0x51 for a read or 0x58 for a write, four address bytes with the most significant byte first, and a final 0xFF where a CRC would normally go.
- R2: With `blockAddr` low, the command address is the sector number times 512, truncated to 32 bits. With `blockAddr` high, it is the sector number with the top byte zero.
- R3: R1 is polled for up to R1_TRIES exchanges, and the first received byte with bit 7 clear is taken as the reply. If no reply arrives in that window, or the reply is nonzero, the engine pulses `error` and drops chip select and enable.
- R4: A read polls until it receives 0xFE. It then writes the next 512 received bytes to consecutive buffer addresses and discards exactly two further bytes.
- R5: A write sends one 0xFF after R1, then 0xFE, then 512 buffer bytes taken in address order, then 0xFF twice.
- R6: After the write CRC bytes, 0xE5 must arrive within 5 read exchanges. Otherwise the engine pulses `error`.
- R7: After 0xE5, the engine reads until it receives 0x00, then reads until it receives 0xFF, then makes exactly 10 more 0xFF exchanges.
- R8: A write when `cardPresent` is low or `writeProtect` is high pulses `wpError`, and a read when `cardPresent` is low pulses `error`. In both cases no exchange takes place.
- R9: After each sector, the remaining count drops by one and the sector number rises by one with 24-bit wraparound. The buffer address starts at 0 for each job and runs on across sectors, so the sectors lie back to back in the buffer.
- R10: `busy` is high while a job runs. After the last sector, `done` pulses with chip select and enable low. A count of zero pulses `done` without any exchange.
- R11: Out of reset the engine is idle, with no request, chip select low, enable low and no outcome pulse.
- R12: At most one exchange is outstanding at a time. A new request is raised only after the previous exchange has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a job when idle |
| writeDir | input | 1 | 1 = write to card, 0 = read from card |
| blockAddr | input | 1 | 1 = card takes block addresses, 0 = byte addresses |
| startSector | input | 24 | First sector number |
| sectorCount | input | 8 | Number of sectors to move |
| cardPresent | input | 1 | Card detect |
| writeProtect | input | 1 | Card write-protect switch |
| xferReq | output | 1 | Starts a one-byte exchange |
| xferTx | output | 8 | Byte to send with the exchange |
| xferDone | input | 1 | Exchange finished |
| xferRx | input | 8 | Byte received during the exchange |
| bufAddr | output | 16 | Buffer byte address |
| bufWe | output | 1 | Buffer write strobe |
| bufWdata | output | 8 | Buffer write data |
| bufRdata | input | 8 | Buffer read data for `bufAddr`, combinational |
| spiEnable | output | 1 | Interface enable |
| chipSelect | output | 1 | Card select, active high |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job completed pulse |
| error | output | 1 | Transfer error pulse |
| wpError | output | 1 | Write-protect or no-card-on-write pulse |

## Verification
The bench uses a behavioural card that logs every command frame and answers with programmable delays. This lets it target the exact edges of each window. The data-response token arrives on the fifth read in one write and on the sixth in another, so an off-by-one response window would either reject the good write or accept the late one. Sector numbers are chosen to cross the 16-bit carry, to wrap at 24 bits, and to check the byte-address shift. A wrong shift or a lost carry shows up directly in the logged address bytes. Exact exchange counts expose a design that skips the filler byte, reads the wrong number of CRC bytes, or sends too few trailing bytes after busy. An R1 that never arrives must end the job after exactly the configured number of polls.

// File: rtl/sdx_pkg.sv
`timescale 1ns/1ps
package sdx_pkg;

  localparam logic [7:0] OP_READ    = 8'h51;
  localparam logic [7:0] OP_WRITE   = 8'h58;
  localparam logic [7:0] TOK_START  = 8'hFE;
  localparam logic [7:0] TOK_ACCEPT = 8'hE5;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;

  typedef enum logic [1:0] {
    TX_FILL,
    TX_CMD,
    TX_TOKEN,
    TX_DATA
  } txSel_t;

  typedef struct packed {
    logic   loadJob;
    logic   nextSector;
    logic   clrIdx;
    logic   incIdx;
    logic   incBuf;
    logic   bufWrite;
    txSel_t txSel;
  } dpCtrl_t;

endpackage

// File: rtl/sdx_datapath.sv
`timescale 1ns/1ps
module sdx_datapath
  import sdx_pkg::*;
#(
  parameter int SEC_W        = 24,
  parameter int CNT_W        = 8,
  parameter int BUF_AW       = 16,
  parameter int IDX_W        = 13,
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctl,
  input  logic [SEC_W-1:0]  startSector,
  input  logic [CNT_W-1:0]  sectorCount,
  input  logic              writeDir,
  input  logic              blockAddr,
  input  logic [7:0]        rxByte,
  input  logic [7:0]        bufRdata,
  output logic [7:0]        txByte,
  output logic [IDX_W-1:0]  idx,
  output logic              lastSector,
  output logic              countZero,
  output logic [BUF_AW-1:0] bufAddr,
  output logic              bufWe,
  output logic [7:0]        bufWdata
);

  localparam int BYTE_SHIFT = $clog2(SECTOR_BYTES);

  logic [SEC_W-1:0]  secNum;
  logic [CNT_W-1:0]  secLeft;
  logic [BUF_AW-1:0] bufPtr;
  logic              isWrite;
  logic              blockMode;
  logic [31:0]       cardAddr;
  logic [7:0]        opcode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secNum    <= '0;
      secLeft   <= '0;
      bufPtr    <= '0;
      isWrite   <= 1'b0;
      blockMode <= 1'b0;
    end else if (ctl.loadJob) begin
      secNum    <= startSector;
      secLeft   <= sectorCount;
      bufPtr    <= '0;
      isWrite   <= writeDir;
      blockMode <= blockAddr;
    end else begin
      if (ctl.nextSector) begin
        secNum  <= secNum + 1'b1;
        secLeft <= secLeft - 1'b1;
      end
      if (ctl.incBuf) bufPtr <= bufPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           idx <= '0;
    else if (ctl.clrIdx)  idx <= '0;
    else if (ctl.incIdx)  idx <= idx + 1'b1;
  end

  always_comb begin
    if (blockMode) cardAddr = 32'(secNum);
    else           cardAddr = 32'(secNum) << BYTE_SHIFT;
  end

  assign opcode = isWrite ? OP_WRITE : OP_READ;

  always_comb begin
    unique case (ctl.txSel)
      TX_CMD: begin
        case (idx[2:0])
          3'd0:    txByte = opcode;
          3'd1:    txByte = cardAddr[31:24];
          3'd2:    txByte = cardAddr[23:16];
          3'd3:    txByte = cardAddr[15:8];
          3'd4:    txByte = cardAddr[7:0];
          default: txByte = FILL_BYTE;
        endcase
      end
      TX_TOKEN: txByte = TOK_START;
      TX_DATA:  txByte = bufRdata;
      default:  txByte = FILL_BYTE;
    endcase
  end

  assign lastSector = (secLeft == CNT_W'(1));
  assign countZero  = (sectorCount == '0);
  assign bufAddr    = bufPtr;
  assign bufWe      = ctl.bufWrite;
  assign bufWdata   = rxByte;

endmodule

// File: rtl/sdx_control.sv
`timescale 1ns/1ps
module sdx_control
  import sdx_pkg::*;
#(
  parameter int IDX_W        = 13,
  parameter int SECTOR_BYTES = 512,
  parameter int R1_TRIES     = 8,
  parameter int TOKEN_TRIES  = 4096,
  parameter int RESP_TRIES   = 5,
  parameter int TAIL_BYTES   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             writeDir,
  input  logic             cardPresent,
  input  logic             writeProtect,
  input  logic             countZero,
  input  logic             lastSector,
  input  logic [IDX_W-1:0] idx,
  input  logic             xferDone,
  input  logic [7:0]       xferRx,
  output dpCtrl_t          ctl,
  output logic             xferReq,
  output logic             spiEnable,
  output logic             chipSelect,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             wpError
);

  localparam logic [IDX_W-1:0] CMD_LAST  = IDX_W'(5);
  localparam logic [IDX_W-1:0] R1_LAST   = IDX_W'(R1_TRIES - 1);
  localparam logic [IDX_W-1:0] TOK_LAST  = IDX_W'(TOKEN_TRIES - 1);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(SECTOR_BYTES - 1);
  localparam logic [IDX_W-1:0] CRC_LAST  = IDX_W'(1);
  localparam logic [IDX_W-1:0] RESP_LAST = IDX_W'(RESP_TRIES - 1);
  localparam logic [IDX_W-1:0] TAIL_LAST = IDX_W'(TAIL_BYTES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_LEAD, S_CMD, S_R1, S_RTOK, S_RDATA, S_RCRC, S_WGAP,
    S_WTOK, S_WDATA, S_WCRC, S_WRESP, S_WBUSY, S_WREADY, S_WTAIL, S_NEXT
  } state_t;

  state_t state, stateN;
  logic   pend;
  logic   isWrite;
  logic   fire;
  logic   exchanging;
  logic   doneN, errN, wpN, linkOn, linkOff;

  assign exchanging = (state != S_IDLE) && (state != S_NEXT);
  assign xferReq    = exchanging && !pend;
  assign fire       = pend && xferDone;
  assign busy       = (state != S_IDLE);

  always_comb begin
    stateN  = state;
    ctl     = '0;
    doneN   = 1'b0;
    errN    = 1'b0;
    wpN     = 1'b0;
    linkOn  = 1'b0;
    linkOff = 1'b0;

    case (state)
      S_CMD:   ctl.txSel = TX_CMD;
      S_WTOK:  ctl.txSel = TX_TOKEN;
      S_WDATA: ctl.txSel = TX_DATA;
      default: ctl.txSel = TX_FILL;
    endcase

    case (state)
      S_IDLE: if (start) begin
        if (countZero) begin
          doneN = 1'b1;
        end else if (writeDir && (!cardPresent || writeProtect)) begin
          wpN = 1'b1;
        end else if (!writeDir && !cardPresent) begin
          errN = 1'b1;
        end else begin
          ctl.loadJob = 1'b1;
          ctl.clrIdx  = 1'b1;
          linkOn      = 1'b1;
          stateN      = S_LEAD;
        end
      end
      S_LEAD: if (fire) begin
        ctl.clrIdx = 1'b1;
        stateN     = S_CMD;
      end
      S_CMD: if (fire) begin
        if (idx == CMD_LAST) begin
          ctl.clrIdx = 1'b1;
          stateN     = S_R1;
        end else ctl.incIdx = 1'b1;
      end
      S_R1: if (fire) begin
        if (!xferRx[7]) begin
          if (xferRx != 8'h00) begin
            errN = 1'b1; linkOff = 1'b1; stateN = S_IDLE;
          end else begin
            ctl.clrIdx = 1'b1;
            stateN     = isWrite ? S_WGAP : S_RTOK;
          end
        end else if (idx == R1_LAST) begin
          errN = 1'b1; linkOff = 1'b1; stateN = S_IDLE;
        end else ctl.incIdx = 1'b1;
      end
      S_RTOK: if (fire) begin
        if (xferRx == TOK_START) begin
          ctl.clrIdx = 1'b1;
          stateN     = S_RDATA;
        end else if (idx == TOK_LAST) begin
          errN = 1'b1; linkOff = 1'b1; stateN = S_IDLE;
        end else ctl.incIdx = 1'b1;
      end
      S_RDATA: if (fire) begin
        ctl.bufWrite = 1'b1;
        ctl.incBuf   = 1'b1;
        if (idx == DATA_LAST) begin
          ctl.clrIdx = 1'b1;
          stateN     = S_RCRC;
        end else ctl.incIdx = 1'b1;
      end
      S_RCRC: if (fire) begin
        if (idx == CRC_LAST) stateN = S_NEXT;
        else ctl.incIdx = 1'b1;
      end
      S_WGAP: if (fire) stateN = S_WTOK;
      S_WTOK: if (fire) begin
        ctl.clrIdx = 1'b1;
        stateN     = S_WDATA;
      end
      S_WDATA: if (fire) begin
        ctl.incBuf = 1'b1;
        if (idx == DATA_LAST) begin
          ctl.clrIdx = 1'b1;
          stateN     = S_WCRC;
        end else ctl.incIdx = 1'b1;
      end
      S_WCRC: if (fire) begin
        if (idx == CRC_LAST) begin
          ctl.clrIdx = 1'b1;
          stateN     = S_WRESP;
        end else ctl.incIdx = 1'b1;
      end
      S_WRESP: if (fire) begin
        if (xferRx == TOK_ACCEPT) stateN = S_WBUSY;
        else if (idx == RESP_LAST) begin
          errN = 1'b1; linkOff = 1'b1; stateN = S_IDLE;
        end else ctl.incIdx = 1'b1;
      end
      S_WBUSY: if (fire && xferRx == 8'h00) stateN = S_WREADY;
      S_WREADY: if (fire && xferRx == FILL_BYTE) begin
        ctl.clrIdx = 1'b1;
        stateN     = S_WTAIL;
      end
      S_WTAIL: if (fire) begin
        if (idx == TAIL_LAST) stateN = S_NEXT;
        else ctl.incIdx = 1'b1;
      end
      S_NEXT: begin
        ctl.nextSector = 1'b1;
        if (lastSector) begin
          doneN = 1'b1; linkOff = 1'b1; stateN = S_IDLE;
        end else begin
          stateN = S_LEAD;
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pend       <= 1'b0;
      isWrite    <= 1'b0;
      spiEnable  <= 1'b0;
      chipSelect <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
      wpError    <= 1'b0;
    end else begin
      state   <= stateN;
      done    <= doneN;
      error   <= errN;
      wpError <= wpN;
      if (xferReq)   pend <= 1'b1;
      else if (fire) pend <= 1'b0;
      if (ctl.loadJob) isWrite <= writeDir;
      if (linkOn) begin
        spiEnable  <= 1'b1;
        chipSelect <= 1'b1;
      end else if (linkOff) begin
        spiEnable  <= 1'b0;
        chipSelect <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sd_sector_engine.sv
`timescale 1ns/1ps
module sd_sector_engine
  import sdx_pkg::*;
#(
  parameter int SEC_W        = 24,
  parameter int CNT_W        = 8,
  parameter int BUF_AW       = 16,
  parameter int SECTOR_BYTES = 512,
  parameter int R1_TRIES     = 8,
  parameter int TOKEN_TRIES  = 4096,
  parameter int RESP_TRIES   = 5,
  parameter int TAIL_BYTES   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              writeDir,
  input  logic              blockAddr,
  input  logic [SEC_W-1:0]  startSector,
  input  logic [CNT_W-1:0]  sectorCount,
  input  logic              cardPresent,
  input  logic              writeProtect,
  output logic              xferReq,
  output logic [7:0]        xferTx,
  input  logic              xferDone,
  input  logic [7:0]        xferRx,
  output logic [BUF_AW-1:0] bufAddr,
  output logic              bufWe,
  output logic [7:0]        bufWdata,
  input  logic [7:0]        bufRdata,
  output logic              spiEnable,
  output logic              chipSelect,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              wpError
);

  localparam int SPAN  = (SECTOR_BYTES > TOKEN_TRIES) ? SECTOR_BYTES : TOKEN_TRIES;
  localparam int IDX_W = $clog2(SPAN) + 1;

  dpCtrl_t          ctl;
  logic [IDX_W-1:0] idx;
  logic             lastSector;
  logic             countZero;

  sdx_control #(
    .IDX_W(IDX_W), .SECTOR_BYTES(SECTOR_BYTES), .R1_TRIES(R1_TRIES),
    .TOKEN_TRIES(TOKEN_TRIES), .RESP_TRIES(RESP_TRIES), .TAIL_BYTES(TAIL_BYTES)
  ) u_ctrl (
    .clk, .rst_n, .start, .writeDir, .cardPresent, .writeProtect,
    .countZero, .lastSector, .idx, .xferDone, .xferRx,
    .ctl, .xferReq, .spiEnable, .chipSelect, .busy, .done, .error, .wpError
  );

  sdx_datapath #(
    .SEC_W(SEC_W), .CNT_W(CNT_W), .BUF_AW(BUF_AW),
    .IDX_W(IDX_W), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_dp (
    .clk, .rst_n, .ctl, .startSector, .sectorCount, .writeDir, .blockAddr,
    .rxByte(xferRx), .bufRdata, .txByte(xferTx), .idx, .lastSector,
    .countZero, .bufAddr, .bufWe, .bufWdata
  );

endmodule

// File: rtl/sd_sector_engine_chk.sv
`timescale 1ns/1ps
module sd_sector_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic xferReq,
  input logic bufWe,
  input logic spiEnable,
  input logic chipSelect,
  input logic busy,
  input logic done,
  input logic error,
  input logic wpError
);

  assert_link_during_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xferReq |-> (chipSelect && spiEnable));

  assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, error, wpError}));

  assert_release_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!chipSelect && !spiEnable));

  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xferReq |=> !xferReq);

  assert_wp_no_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wpError |-> (!chipSelect && !xferReq));

  assert_store_in_job_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bufWe |-> (busy && chipSelect));

endmodule

bind sd_sector_engine sd_sector_engine_chk u_chk (.*);

// File: tb/sd_sector_engine_test.sv
`timescale 1ns/1ps
module sd_sector_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, writeDir, blockAddr, cardPresent, writeProtect;
  logic [23:0] startSector;
  logic [7:0]  sectorCount;
  logic        xferReq;
  logic [7:0]  xferTx;
  logic        xferDone;
  logic [7:0]  xferRx;
  logic [15:0] bufAddr;
  logic        bufWe;
  logic [7:0]  bufWdata, bufRdata;
  logic        spiEnable, chipSelect, busy, done, error, wpError;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sd_sector_engine uut (
    .clk, .rst_n, .start, .writeDir, .blockAddr, .startSector, .sectorCount,
    .cardPresent, .writeProtect, .xferReq, .xferTx, .xferDone, .xferRx,
    .bufAddr, .bufWe, .bufWdata, .bufRdata, .spiEnable, .chipSelect,
    .busy, .done, .error, .wpError
  );

  // host buffer
  logic [7:0] hostMem [0:4095];
  assign bufRdata = hostMem[bufAddr[11:0]];
  always @(posedge clk) if (bufWe) hostMem[bufAddr[11:0]] <= bufWdata;

  // behavioural card
  localparam int C_IDLE = 0, C_CMD = 1, C_R1 = 2, C_RTOK = 3, C_RDATA = 4,
                 C_RCRC = 5, C_WWAIT = 6, C_WDATA = 7, C_WCRC = 8,
                 C_WRESP = 9, C_BUSY = 10;
  int cst = C_IDLE;
  int r1Delay, tokDelay, respDelay, busyLen;
  logic [7:0] r1Val;
  logic [7:0] logCmd [0:7];
  logic [31:0] logAddr [0:7];
  logic [7:0] logCrc [0:7];
  logic [7:0] cardData [0:1023];
  int nCmd, nXfer, gap, crcBad, tail, wrBase, overlap = 0;
  bit countTail;
  bit reqLast = 1'b0;
  logic [7:0] curCmd, tx, rx;
  logic [31:0] curAddr;
  int nb, k, i;

  function automatic logic [7:0] pat(input logic [31:0] a, input int n);
    return 8'(int'(a[7:0]) + 3 * int'(a[15:8]) + 5 * int'(a[23:16]) + 7 * n + (n >> 8));
  endfunction

  initial begin
    xferDone = 1'b0;
    xferRx   = 8'hFF;
  end

  always @(posedge clk) begin
    xferDone <= 1'b0;
    if (xferReq && reqLast) overlap++;
    reqLast = xferReq;
    if (!chipSelect) cst = C_IDLE;
    if (xferReq) begin
      nXfer++;
      tx = xferTx;
      rx = 8'hFF;
      case (cst)
        C_IDLE: begin
          if (tx[7:6] == 2'b01) begin
            cst = C_CMD; curCmd = tx; nb = 0; curAddr = '0; countTail = 1'b0;
          end else if (countTail) tail++;
        end
        C_CMD: begin
          if (nb < 4) begin
            curAddr = {curAddr[23:0], tx}; nb++;
          end else begin
            if (nCmd < 8) begin
              logCmd[nCmd] = curCmd; logAddr[nCmd] = curAddr; logCrc[nCmd] = tx;
            end
            nCmd++; cst = C_R1; k = 0;
          end
        end
        C_R1: begin
          if (k < r1Delay) k++;
          else begin
            rx = r1Val;
            if (r1Val != 8'h00) cst = C_IDLE;
            else if (curCmd == 8'h58) cst = C_WWAIT;
            else begin cst = C_RTOK; k = 0; end
          end
        end
        C_RTOK: begin
          if (k < tokDelay) k++;
          else begin rx = 8'hFE; cst = C_RDATA; i = 0; end
        end
        C_RDATA: begin
          rx = pat(curAddr, i); i++;
          if (i == 512) begin cst = C_RCRC; k = 0; end
        end
        C_RCRC: begin
          rx = 8'h5A; k++;
          if (k == 2) cst = C_IDLE;
        end
        C_WWAIT: begin
          if (tx == 8'hFE) begin cst = C_WDATA; i = 0; end
          else gap++;
        end
        C_WDATA: begin
          if (wrBase + i < 1024) cardData[wrBase + i] = tx;
          i++;
          if (i == 512) begin cst = C_WCRC; k = 0; end
        end
        C_WCRC: begin
          if (tx != 8'hFF) crcBad++;
          k++;
          if (k == 2) begin cst = C_WRESP; k = 0; wrBase += 512; end
        end
        C_WRESP: begin
          if (k < respDelay) k++;
          else begin rx = 8'hE5; cst = C_BUSY; k = 0; end
        end
        C_BUSY: begin
          if (k < busyLen) begin rx = 8'h00; k++; end
          else begin rx = 8'hFF; cst = C_IDLE; countTail = 1'b1; tail = 0; end
        end
        default: cst = C_IDLE;
      endcase
      xferRx   <= rx;
      xferDone <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cardSetup(input int r1d, input logic [7:0] r1v, input int tokd,
                           input int respd, input int busyl);
    r1Delay = r1d; r1Val = r1v; tokDelay = tokd; respDelay = respd; busyLen = busyl;
    nCmd = 0; nXfer = 0; gap = 0; crcBad = 0; tail = 0; countTail = 1'b0; wrBase = 0;
  endtask

  // outcome: 1 done, 2 error, 3 wpError, 0 none
  task automatic runJob(input bit wr, input bit blk, input logic [23:0] sec,
                        input logic [7:0] cnt, input bit present, input bit wp,
                        output int outcome, output bit sawBusy);
    int cyc;
    @(negedge clk);
    writeDir = wr; blockAddr = blk; startSector = sec; sectorCount = cnt;
    cardPresent = present; writeProtect = wp; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    outcome = 0; sawBusy = 1'b0; cyc = 0;
    while (outcome == 0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (busy) sawBusy = 1'b1;
      if (done) outcome = 1;
      else if (error) outcome = 2;
      else if (wpError) outcome = 3;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset;
    check(!busy && !xferReq, "R11 reset idle", {busy, xferReq}, 0);
    check(!chipSelect && !spiEnable, "R11 reset link off", {chipSelect, spiEnable}, 0);
    check(!done && !error && !wpError, "R11 reset no outcome", {done, error, wpError}, 0);
  endtask

  task automatic testReadSingle;
    int oc, mis; bit sb;
    cardSetup(2, 8'h00, 3, 0, 1);
    runJob(1'b0, 1'b1, 24'h000123, 8'd1, 1'b1, 1'b0, oc, sb);
    check(oc == 1, "R10 read single done", oc, 1);
    check(sb, "R10 busy during job", sb, 1);
    check(!chipSelect && !spiEnable, "R10 link released", {chipSelect, spiEnable}, 0);
    check(nCmd == 1 && logCmd[0] == 8'h51, "R1 read opcode", logCmd[0], 8'h51);
    check(logCrc[0] == 8'hFF, "R1 crc filler", logCrc[0], 8'hFF);
    check(logAddr[0] == 32'h0000_0123, "R2 block address", logAddr[0], 32'h123);
    mis = 0;
    for (int n = 0; n < 512; n++) if (hostMem[n] != pat(32'h123, n)) mis++;
    check(mis == 0, "R4 read data stored", mis, 0);
    check(nXfer == 528, "R4 read exchange count", nXfer, 528);
  endtask

  task automatic testReadMultiByte;
    int oc, mis; bit sb;
    cardSetup(0, 8'h00, 0, 0, 1);
    runJob(1'b0, 1'b0, 24'h00FFFF, 8'd2, 1'b1, 1'b0, oc, sb);
    check(oc == 1, "R9 multi read done", oc, 1);
    check(nCmd == 2, "R9 two commands", nCmd, 2);
    check(logAddr[0] == 32'h01FF_FE00, "R2 byte address", logAddr[0], 32'h01FFFE00);
    check(logAddr[1] == 32'h0200_0000, "R9 sector carry", logAddr[1], 32'h02000000);
    mis = 0;
    for (int n = 0; n < 512; n++) begin
      if (hostMem[n] != pat(32'h01FFFE00, n)) mis++;
      if (hostMem[512 + n] != pat(32'h02000000, n)) mis++;
    end
    check(mis == 0, "R9 sectors back to back", mis, 0);
  endtask

  task automatic testReadWrap;
    int oc; bit sb;
    cardSetup(0, 8'h00, 1, 0, 1);
    runJob(1'b0, 1'b1, 24'hFFFFFF, 8'd2, 1'b1, 1'b0, oc, sb);
    check(oc == 1, "R9 wrap done", oc, 1);
    check(logAddr[0] == 32'h00FF_FFFF, "R2 block top byte zero", logAddr[0], 32'h00FFFFFF);
    check(logAddr[1] == 32'h0000_0000, "R9 24-bit wrap", logAddr[1], 0);
  endtask

  task automatic testWriteSingle;
    int oc, mis; bit sb;
    for (int n = 0; n < 1024; n++) hostMem[n] = 8'(n * 11 + (n >> 8) * 5 + 1);
    cardSetup(0, 8'h00, 0, 4, 3);
    runJob(1'b1, 1'b1, 24'h000042, 8'd1, 1'b1, 1'b0, oc, sb);
    check(oc == 1, "R6 token on fifth read accepted", oc, 1);
    check(logCmd[0] == 8'h58, "R1 write opcode", logCmd[0], 8'h58);
    check(logAddr[0] == 32'h42, "R2 write block address", logAddr[0], 32'h42);
    check(gap == 1, "R5 one filler after R1", gap, 1);
    check(crcBad == 0, "R5 crc bytes are FF", crcBad, 0);
    mis = 0;
    for (int n = 0; n < 512; n++) if (cardData[n] != hostMem[n]) mis++;
    check(mis == 0, "R5 payload from buffer", mis, 0);
    check(tail == 10, "R7 ten trailing bytes", tail, 10);
    check(nXfer == 543, "R7 write exchange count", nXfer, 543);
  endtask

  task automatic testWriteLate;
    int oc; bit sb;
    cardSetup(0, 8'h00, 0, 5, 1);
    runJob(1'b1, 1'b1, 24'h000007, 8'd1, 1'b1, 1'b0, oc, sb);
    check(oc == 2, "R6 token on sixth read rejected", oc, 2);
    check(!chipSelect && !spiEnable, "R6 link released on error", {chipSelect, spiEnable}, 0);
  endtask

  task automatic testWriteMulti;
    int oc, mis; bit sb;
    cardSetup(1, 8'h00, 0, 0, 2);
    runJob(1'b1, 1'b0, 24'h000010, 8'd2, 1'b1, 1'b0, oc, sb);
    check(oc == 1, "R9 multi write done", oc, 1);
    check(logAddr[0] == 32'h2000 && logAddr[1] == 32'h2200, "R9 write addresses",
          logAddr[1], 32'h2200);
    mis = 0;
    for (int n = 0; n < 512; n++) if (cardData[512 + n] != hostMem[512 + n]) mis++;
    check(mis == 0, "R9 second sector from next buffer half", mis, 0);
  endtask

  task automatic testGuards;
    int oc; bit sb;
    cardSetup(0, 8'h00, 0, 0, 1);
    runJob(1'b1, 1'b1, 24'h1, 8'd1, 1'b1, 1'b1, oc, sb);
    check(oc == 3 && nXfer == 0, "R8 write protect", oc, 3);
    runJob(1'b1, 1'b1, 24'h1, 8'd1, 1'b0, 1'b0, oc, sb);
    check(oc == 3 && nXfer == 0, "R8 write no card", oc, 3);
    runJob(1'b0, 1'b1, 24'h1, 8'd1, 1'b0, 1'b0, oc, sb);
    check(oc == 2 && nXfer == 0, "R8 read no card", oc, 2);
    runJob(1'b0, 1'b1, 24'h1, 8'd0, 1'b1, 1'b0, oc, sb);
    check(oc == 1 && nXfer == 0, "R10 zero count", nXfer, 0);
  endtask

  task automatic testR1Faults;
    int oc; bit sb;
    cardSetup(1, 8'h04, 0, 0, 1);
    runJob(1'b0, 1'b1, 24'h5, 8'd1, 1'b1, 1'b0, oc, sb);
    check(oc == 2, "R3 nonzero R1", oc, 2);
    cardSetup(40, 8'h00, 0, 0, 1);
    runJob(1'b0, 1'b1, 24'h5, 8'd1, 1'b1, 1'b0, oc, sb);
    check(oc == 2, "R3 R1 timeout", oc, 2);
    check(nXfer == 15, "R3 poll window", nXfer, 15);
    check(!chipSelect, "R3 select dropped", chipSelect, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; writeDir = 1'b0; blockAddr = 1'b0;
    startSector = '0; sectorCount = '0; cardPresent = 1'b1; writeProtect = 1'b0;
    cardSetup(0, 8'h00, 0, 0, 1);
    repeat (4) @(negedge clk);
    testReset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testReset;
    testReadSingle;
    testReadMultiByte;
    testReadWrap;
    testWriteSingle;
    testWriteLate;
    testWriteMulti;
    testGuards;
    testR1Faults;
    check(overlap == 0, "R12 single outstanding exchange", overlap, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule